// File: doc/BRIEF.md
# SCSI Message-In Parser

This block sits on the initiator side of a parallel SCSI bus and decodes the bytes a target sends while the bus is in the message-in phase. Bytes arrive on a request/acknowledge interface. The parser samples a byte whenever `req_i` is high and the phase is message-in. It answers with a one-cycle `ack_o` once the byte has been taken. The target must drop `req_i` before the next clock edge. The first byte of a message decides its class. Single-byte messages produce an event at once. Extended messages gather a length byte, a code byte and their arguments first. IDENTIFY opens a reconnect, which may be followed by a simple queue tag.

Every result appears as a one-cycle pulse on `evt_valid_o`. The pulse carries an event code on `evt_o` and its arguments on `lun_o`, `tag_o`, `arg_a_o` and `arg_b_o`. When the initiator must answer with a message of its own, `atn_o` pulses for one cycle and `msgout_o` holds the byte to send. That byte is a reject for malformed input, or an abort-tag for a tag outside the configured SCB count. In both cases the offending byte is acknowledged one cycle after ATN is raised. Looking up the matching SCB and the driver's reaction to an event are handled outside this block.

Top module: `msgin_parser`

## Requirements
- R1: After reset, `ack_o`, `atn_o` and `evt_valid_o` are low until a byte is presented.
- R2: The single-byte codes 0x00, 0x02, 0x03, 0x04 and 0x07 produce the events 1 (command complete), 3 (save pointers), 4 (restore pointers), 2 (disconnect) and 5 (reject received). The event and `ack_o` pulse together in the cycle that follows the sampling edge.
- R3: Any other first byte below 0x80, apart from 0x01, produces event 9 (send reject). In that same cycle `atn_o` pulses with `msgout_o` = 0x07. `ack_o` follows one cycle later.
- R4: A first byte with bit 7 set and bits 6:3 all clear is IDENTIFY. It is acknowledged with no event, and its LUN is taken from bits 2:0. If any of bits 6:3 is set, the byte is rejected as in R3.
- R5: The byte after IDENTIFY may not be 0x20, or it may come in a phase other than message-in. In either case event 8 (reselect) is raised with the LUN and tag 0xFF, and that byte is not acknowledged. A message-in byte of this kind is then parsed afresh as a first byte.
- R6: After IDENTIFY, a 0x20 byte is acknowledged with no event. A following tag below SCB_COUNT is acknowledged together with event 8, carrying the tag on `tag_o`.
- R7: A tag at or above SCB_COUNT raises event 10 (abort tag) with the tag on `tag_o`. In the same cycle `atn_o` pulses with `msgout_o` = 0x0D, and `ack_o` follows one cycle later.
- R8: The extended sequence 0x01, length 2, code 0x03, width produces event 6 together with the ack of the width byte, with the width on `arg_a_o`.
- R9: The extended sequence 0x01, length 3, code 0x01, period, offset produces event 7 together with the ack of the offset byte, with the period on `arg_a_o` and the offset on `arg_b_o`.
- R10: Any other pairing of extended length and code is rejected on the code byte, as in R3.
- R11: Suppose a further byte is expected (extended length, code or arguments, or the tag after 0x20), and `req_i` rises in a phase other than message-in. Then event 11 (phase mismatch) is raised with no acknowledge, and the parser returns to idle.
- R12: Each accepted byte is acknowledged exactly once, with a single-cycle `ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Target requests a byte transfer |
| msgin_i | input | 1 | Bus phase is message-in |
| data_i | input | 8 | Byte on the bus |
| ack_o | output | 1 | One-cycle acknowledge of the sampled byte |
| atn_o | output | 1 | One-cycle request to raise ATN |
| msgout_o | output | 8 | Message byte to queue for message-out, valid with `atn_o` |
| evt_valid_o | output | 1 | Event pulse |
| evt_o | output | 4 | Event code |
| lun_o | output | 3 | LUN from IDENTIFY |
| tag_o | output | 8 | Tag for reselect or abort-tag |
| arg_a_o | output | 8 | Width or sync period |
| arg_b_o | output | 8 | Sync offset |

## Verification
A rejection and an abort-tag both raise the event and the ATN request in the same cycle, while the acknowledge is held back by one cycle. The bench provokes this by sweeping every first-byte value, every extended length/code pair and every tag value. It then compares the cycle indices of event, ATN and ack against the arithmetic expectation. The untagged reconnect end and the fresh parse of the same unacknowledged byte land in adjacent cycles. The bench checks that the first and last events seen during one held request are the reselect and the new message.

// File: rtl/msgin_pkg.sv
package msgin_pkg;
  typedef enum logic [3:0] {
    EV_NONE        = 4'd0,
    EV_CMD_DONE    = 4'd1,
    EV_DISCONNECT  = 4'd2,
    EV_SAVE_PTRS   = 4'd3,
    EV_RESTORE     = 4'd4,
    EV_REJ_RCVD    = 4'd5,
    EV_WIDTH       = 4'd6,
    EV_SYNC        = 4'd7,
    EV_RESELECT    = 4'd8,
    EV_SEND_REJECT = 4'd9,
    EV_ABORT_TAG   = 4'd10,
    EV_PHASE_MIS   = 4'd11
  } evt_e;

  typedef enum logic [1:0] {CLS_SIMPLE, CLS_EXT, CLS_IDENT, CLS_BAD} cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXT_LEN, ST_EXT_CODE, ST_ARG_A, ST_ARG_B, ST_SNOOP, ST_TAG, ST_ACK_LATE
  } state_e;

  localparam logic [7:0] MO_REJECT    = 8'h07;
  localparam logic [7:0] MO_ABORT_TAG = 8'h0D;
  localparam logic [7:0] SIMPLE_TAG   = 8'h20;
  localparam logic [7:0] NULL_TAG     = 8'hFF;
  localparam logic [7:0] CODE_WIDE    = 8'h03;
  localparam logic [7:0] CODE_SYNC    = 8'h01;
endpackage

// File: rtl/msgin_first_class.sv
module msgin_first_class
  import msgin_pkg::*;
(
  input  logic [7:0] byte_i,
  output cls_e       cls_o,
  output evt_e       evt_o
);
  always_comb begin
    cls_o = CLS_BAD;
    evt_o = EV_NONE;
    if (byte_i[7]) begin
      cls_o = (byte_i[6:3] == 4'd0) ? CLS_IDENT : CLS_BAD;
    end else begin
      unique case (byte_i)
        8'h00:   begin cls_o = CLS_SIMPLE; evt_o = EV_CMD_DONE;   end
        8'h01:   begin cls_o = CLS_EXT;                           end
        8'h02:   begin cls_o = CLS_SIMPLE; evt_o = EV_SAVE_PTRS;  end
        8'h03:   begin cls_o = CLS_SIMPLE; evt_o = EV_RESTORE;    end
        8'h04:   begin cls_o = CLS_SIMPLE; evt_o = EV_DISCONNECT; end
        8'h07:   begin cls_o = CLS_SIMPLE; evt_o = EV_REJ_RCVD;   end
        default: begin cls_o = CLS_BAD;                           end
      endcase
    end
  end
endmodule

// File: rtl/msgin_tag_range.sv
module msgin_tag_range #(
  parameter int unsigned SCB_COUNT = 16
) (
  input  logic [7:0] tag_i,
  output logic       ok_o
);
  localparam logic [8:0] CNT9 = 9'(SCB_COUNT);
  assign ok_o = ({1'b0, tag_i} < CNT9);
endmodule

// File: rtl/msgin_parser.sv
module msgin_parser
  import msgin_pkg::*;
#(
  parameter int unsigned SCB_COUNT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       msgin_i,
  input  logic [7:0] data_i,
  output logic       ack_o,
  output logic       atn_o,
  output logic [7:0] msgout_o,
  output logic       evt_valid_o,
  output logic [3:0] evt_o,
  output logic [2:0] lun_o,
  output logic [7:0] tag_o,
  output logic [7:0] arg_a_o,
  output logic [7:0] arg_b_o
);
  localparam logic [8:0] CNT9 = 9'(SCB_COUNT);

  state_e     state_q;
  evt_e       evt_q;
  cls_e       cls;
  evt_e       simple_evt;
  logic       tag_ok;
  logic       ack_q, atn_q, sync_q;
  logic [7:0] msgout_q, tag_q, arg_a_q, arg_b_q, len_q;
  logic [2:0] lun_q;

  msgin_first_class i_class (.byte_i(data_i), .cls_o(cls), .evt_o(simple_evt));
  msgin_tag_range #(.SCB_COUNT(SCB_COUNT)) i_tag (.tag_i(data_i), .ok_o(tag_ok));

  // a byte is taken only once per request; mis flags a request outside message-in
  logic take, mis;
  assign take = req_i && msgin_i && !ack_q;
  assign mis  = req_i && !msgin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      evt_q    <= EV_NONE;
      ack_q    <= 1'b0;
      atn_q    <= 1'b0;
      sync_q   <= 1'b0;
      msgout_q <= 8'h00;
      tag_q    <= NULL_TAG;
      arg_a_q  <= 8'h00;
      arg_b_q  <= 8'h00;
      len_q    <= 8'h00;
      lun_q    <= 3'd0;
    end else begin
      ack_q <= 1'b0;
      atn_q <= 1'b0;
      evt_q <= EV_NONE;
      unique case (state_q)
        ST_IDLE: if (take) begin
          unique case (cls)
            CLS_SIMPLE: begin ack_q <= 1'b1; evt_q <= simple_evt; end
            CLS_EXT:    begin ack_q <= 1'b1; state_q <= ST_EXT_LEN; end
            CLS_IDENT:  begin ack_q <= 1'b1; lun_q <= data_i[2:0]; state_q <= ST_SNOOP; end
            default: begin
              atn_q <= 1'b1; msgout_q <= MO_REJECT; evt_q <= EV_SEND_REJECT;
              state_q <= ST_ACK_LATE;
            end
          endcase
        end
        ST_EXT_LEN: begin
          if (mis) begin evt_q <= EV_PHASE_MIS; state_q <= ST_IDLE; end
          else if (take) begin len_q <= data_i; ack_q <= 1'b1; state_q <= ST_EXT_CODE; end
        end
        ST_EXT_CODE: begin
          if (mis) begin evt_q <= EV_PHASE_MIS; state_q <= ST_IDLE; end
          else if (take) begin
            if (data_i == CODE_WIDE && len_q == 8'd2) begin
              ack_q <= 1'b1; sync_q <= 1'b0; state_q <= ST_ARG_A;
            end else if (data_i == CODE_SYNC && len_q == 8'd3) begin
              ack_q <= 1'b1; sync_q <= 1'b1; state_q <= ST_ARG_A;
            end else begin
              atn_q <= 1'b1; msgout_q <= MO_REJECT; evt_q <= EV_SEND_REJECT;
              state_q <= ST_ACK_LATE;
            end
          end
        end
        ST_ARG_A: begin
          if (mis) begin evt_q <= EV_PHASE_MIS; state_q <= ST_IDLE; end
          else if (take) begin
            arg_a_q <= data_i; ack_q <= 1'b1;
            if (sync_q) state_q <= ST_ARG_B;
            else begin evt_q <= EV_WIDTH; state_q <= ST_IDLE; end
          end
        end
        ST_ARG_B: begin
          if (mis) begin evt_q <= EV_PHASE_MIS; state_q <= ST_IDLE; end
          else if (take) begin
            arg_b_q <= data_i; ack_q <= 1'b1; evt_q <= EV_SYNC; state_q <= ST_IDLE;
          end
        end
        ST_SNOOP: begin
          // a non-tag byte is left unacknowledged for the idle state to parse
          if (mis || (take && data_i != SIMPLE_TAG)) begin
            tag_q <= NULL_TAG; evt_q <= EV_RESELECT; state_q <= ST_IDLE;
          end else if (take) begin
            ack_q <= 1'b1; state_q <= ST_TAG;
          end
        end
        ST_TAG: begin
          if (mis) begin evt_q <= EV_PHASE_MIS; state_q <= ST_IDLE; end
          else if (take) begin
            tag_q <= data_i;
            if (tag_ok) begin
              ack_q <= 1'b1; evt_q <= EV_RESELECT; state_q <= ST_IDLE;
            end else begin
              atn_q <= 1'b1; msgout_q <= MO_ABORT_TAG; evt_q <= EV_ABORT_TAG;
              state_q <= ST_ACK_LATE;
            end
          end
        end
        ST_ACK_LATE: begin ack_q <= 1'b1; state_q <= ST_IDLE; end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o       = ack_q;
  assign atn_o       = atn_q;
  assign msgout_o    = msgout_q;
  assign evt_valid_o = (evt_q != EV_NONE);
  assign evt_o       = evt_q;
  assign lun_o       = lun_q;
  assign tag_o       = tag_q;
  assign arg_a_o     = arg_a_q;
  assign arg_b_o     = arg_b_q;

  p_ack_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_atn_then_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atn_o |=> ack_o);
  p_reject_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_q == EV_SEND_REJECT) |-> (atn_o && msgout_o == MO_REJECT && !ack_o));
  p_abort_tag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_q == EV_ABORT_TAG) |-> (atn_o && msgout_o == MO_ABORT_TAG
                                                && {1'b0, tag_o} >= CNT9));
  p_reselect_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_q == EV_RESELECT) |-> (tag_o == NULL_TAG || {1'b0, tag_o} < CNT9));
  p_mismatch_noack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_q == EV_PHASE_MIS) |-> (!ack_o && !atn_o));
endmodule

// File: tb/test_msgin_parser.sv
`timescale 1ns/1ps
module test_msgin_parser;
  localparam int CNT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, msgin = 1'b0;
  logic [7:0] data = 8'h00;
  logic ack, atn, evv;
  logic [7:0] mo, tag, arga, argb;
  logic [3:0] ev;
  logic [2:0] lun;

  int nchk = 0, nerr = 0;

  logic [3:0] ob_ev, ob_evc, ob_ack, ob_atn, ob_last;
  logic [7:0] ob_mo, ob_tag, ob_a, ob_b;
  logic [2:0] ob_lun;

  always #2.5 clk = ~clk;

  msgin_parser #(.SCB_COUNT(CNT)) i_msgin_parser (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .msgin_i(msgin), .data_i(data),
    .ack_o(ack), .atn_o(atn), .msgout_o(mo), .evt_valid_o(evv), .evt_o(ev),
    .lun_o(lun), .tag_o(tag), .arg_a_o(arga), .arg_b_o(argb)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // present one byte; record event/ATN/ack cycle indices (1 = cycle after sampling edge)
  task automatic xfer(input logic [7:0] d, input logic ph);
    ob_ev = 0; ob_evc = 0; ob_ack = 0; ob_atn = 0; ob_last = 0;
    ob_mo = 0; ob_tag = 0; ob_a = 0; ob_b = 0; ob_lun = 0;
    data = d; msgin = ph; req = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (evv) begin
        if (ob_evc == 0) begin
          ob_ev = ev; ob_evc = c[3:0]; ob_tag = tag; ob_a = arga; ob_b = argb; ob_lun = lun;
        end
        ob_last = ev;
      end
      if (atn && ob_atn == 0) begin ob_atn = c[3:0]; ob_mo = mo; end
      if (ack) begin ob_ack = c[3:0]; break; end
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_x(input string rq, input string what,
                          input int e, input int ec, input int ac, input int at);
    logic [15:0] a, x;
    a = {ob_ev, ob_evc, ob_ack, ob_atn};
    x = {e[3:0], ec[3:0], ac[3:0], at[3:0]};
    chk(a == x, rq, what, a, x);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ack, atn, evv} == 3'b000, "R1", "reset outputs", {ack, atn, evv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ack, atn, evv} == 3'b000, "R1", "idle outputs", {ack, atn, evv}, 0);

    // R2 R3 R4 sweep of every first byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bb = b[7:0];
      xfer(bb, 1'b1);
      if (bb[7] && bb[6:3] == 4'd0) begin
        expect_x("R4", "identify accepted", 0, 0, 1, 0);
        xfer(8'h00, 1'b0);
        expect_x("R5", "untagged reselect on phase change", 8, 1, 0, 0);
        chk(ob_lun == bb[2:0] && ob_tag == 8'hFF, "R5", "lun/tag",
            {ob_lun, ob_tag}, {bb[2:0], 8'hFF});
      end else if (bb == 8'h01) begin
        expect_x("R2", "extended start", 0, 0, 1, 0);
        xfer(8'h02, 1'b0);
        expect_x("R11", "mismatch at length", 11, 1, 0, 0);
      end else if (bb == 8'h00 || bb == 8'h02 || bb == 8'h03 || bb == 8'h04 || bb == 8'h07) begin
        int e;
        e = (bb == 8'h00) ? 1 : (bb == 8'h02) ? 3 : (bb == 8'h03) ? 4 : (bb == 8'h04) ? 2 : 5;
        expect_x("R2", "simple message", e, 1, 1, 0);
      end else begin
        expect_x(bb[7] ? "R4" : "R3", "rejected first byte", 9, 1, 2, 1);
        chk(ob_mo == 8'h07, "R3", "reject byte", ob_mo, 8'h07);
      end
    end

    // R5 non-tag byte after identify is reparsed
    xfer(8'h85, 1'b1);
    xfer(8'h04, 1'b1);
    expect_x("R5", "reselect then reparse", 8, 1, 2, 0);
    chk(ob_last == 4'd2 && ob_lun == 3'd5 && ob_tag == 8'hFF, "R5", "reparsed as disconnect",
        {ob_last, ob_lun, ob_tag}, {4'd2, 3'd5, 8'hFF});

    // R6 R7 tag sweep
    for (int t = 0; t < 256; t++) begin
      xfer(8'h80 | 8'(t & 7), 1'b1);
      xfer(8'h20, 1'b1);
      expect_x("R6", "simple tag byte", 0, 0, 1, 0);
      xfer(t[7:0], 1'b1);
      if (t < CNT) begin
        expect_x("R6", "tagged reselect", 8, 1, 1, 0);
        chk(ob_tag == t[7:0] && ob_lun == 3'(t & 7), "R6", "tag/lun",
            {ob_lun, ob_tag}, {3'(t & 7), t[7:0]});
      end else begin
        expect_x("R7", "abort tag", 10, 1, 2, 1);
        chk(ob_mo == 8'h0D && ob_tag == t[7:0], "R7", "abort byte/tag",
            {ob_mo, ob_tag}, {8'h0D, t[7:0]});
      end
    end

    // R11 mismatch while tag expected
    xfer(8'h81, 1'b1); xfer(8'h20, 1'b1); xfer(8'h05, 1'b0);
    expect_x("R11", "mismatch at tag", 11, 1, 0, 0);

    // R8 R9 R10 sweep of extended length and code
    for (int l = 0; l < 8; l++) begin
      for (int k = 0; k < 8; k++) begin
        xfer(8'h01, 1'b1);
        xfer(l[7:0], 1'b1);
        xfer(k[7:0], 1'b1);
        if (k == 3 && l == 2) begin
          expect_x("R8", "wide code", 0, 0, 1, 0);
          xfer(8'(l * 16 + k), 1'b1);
          expect_x("R8", "width event", 6, 1, 1, 0);
          chk(ob_a == 8'(l * 16 + k), "R8", "width arg", ob_a, 8'(l * 16 + k));
        end else if (k == 1 && l == 3) begin
          expect_x("R9", "sync code", 0, 0, 1, 0);
          xfer(8'h32, 1'b1);
          expect_x("R9", "period byte", 0, 0, 1, 0);
          xfer(8'h0F, 1'b1);
          expect_x("R9", "sync event", 7, 1, 1, 0);
          chk(ob_a == 8'h32 && ob_b == 8'h0F, "R9", "period/offset", {ob_a, ob_b}, 16'h320F);
        end else begin
          expect_x("R10", "bad extended pair", 9, 1, 2, 1);
          chk(ob_mo == 8'h07, "R10", "reject byte", ob_mo, 8'h07);
        end
      end
    end

    // R11 mismatch at code and at each argument
    xfer(8'h01, 1'b1); xfer(8'h03, 1'b1); xfer(8'h01, 1'b0);
    expect_x("R11", "mismatch at code", 11, 1, 0, 0);
    xfer(8'h01, 1'b1); xfer(8'h03, 1'b1); xfer(8'h01, 1'b1); xfer(8'h19, 1'b0);
    expect_x("R11", "mismatch at period", 11, 1, 0, 0);
    xfer(8'h01, 1'b1); xfer(8'h03, 1'b1); xfer(8'h01, 1'b1); xfer(8'h19, 1'b1);
    xfer(8'h08, 1'b0);
    expect_x("R11", "mismatch at offset", 11, 1, 0, 0);
    // after mismatch the parser is idle again (R12 single ack)
    xfer(8'h00, 1'b1);
    expect_x("R12", "recovery command complete", 1, 1, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule